// File: doc/BRIEF.md
# Radix-2 FFT Address Generator

This block runs beside a small DSP pipeline and supplies the memory addresses for an in-place radix-2 FFT. A start strobe captures the transform size, the pass type and two base addresses: one for the data buffer and one for the twiddle table. While a run is in progress, the block presents one operand set at a time. In butterfly mode a set is two data addresses and one twiddle address. In reorder mode a set is a natural-order and bit-reversed address pair. The decode stage consumes a set and pulses `step_i` to move to the next one.

Sizes of 4, 8, 16 and 32 points can be chosen at run time. The memory holds 128 words, so every address is 7 bits wide and wraps modulo 128. When the last set has been consumed, a one-cycle done pulse is raised and the block stays idle until the next start.

Top module: `fft_agu`

## Requirements
- R1: After reset, `valid_o` and `done_o` are 0.
- R2: A start accepted while idle raises `valid_o` in the next cycle. The first set presented is stage 0, index 0.
- R3: The size code selects log2 N as follows: 0 gives 2, 1 gives 3, 2 gives 4 and 3 gives 5. Codes 4 to 7 are handled as code 0 (4 points).
- R4: A butterfly run presents (N/2)·log2 N sets. Stages go in ascending order from 0 to log2 N−1, and within each stage `bfly_o` counts from 0 to N/2−1.
- R5: For stage s and in-stage index k, let span = 2^s, g = k div span and j = k mod span. Then `addr_a_o` = data base + 2·g·span + j and `addr_b_o` = `addr_a_o` + span.
- R6: The twiddle address is twiddle base + j·N/2^(s+1), where j is defined as in R5.
- R7: Reorder mode (`mode_i`=1) presents N sets with `stage_o`=0 and `bfly_o`=j. For each set, `addr_a_o` = data base + j, `addr_b_o` = data base + bitrev(j) over log2 N bits, and `twid_addr_o` = twiddle base.
- R8: The presented set changes only on a cycle where `step_i` is high. Without a step, all outputs hold.
- R9: `done_o` is high for exactly one cycle, in the cycle after the step that consumes the last set. `valid_o` is 0 in that cycle.
- R10: A start while a run is busy is ignored: the bases, size and mode stay as they were.
- R11: All address sums wrap modulo 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request (accepted only when idle) |
| mode_i | input | 1 | 0 = butterfly addresses, 1 = bit-reversal reorder pass |
| size_sel_i | input | 3 | Transform size code |
| data_base_i | input | 7 | Data buffer base address |
| twid_base_i | input | 7 | Twiddle table base address |
| step_i | input | 1 | Current set consumed; advance |
| addr_a_o | output | 7 | First data operand address |
| addr_b_o | output | 7 | Second data operand address |
| twid_addr_o | output | 7 | Twiddle factor address |
| valid_o | output | 1 | A set is presented |
| stage_o | output | 3 | Current stage |
| bfly_o | output | 5 | Index within stage |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
All outputs come straight from registered run state. The first set is therefore due one edge after the start. Each later set is due one edge after the step that consumes the set before it, and the done pulse is due one edge after the final step. The bench changes inputs and samples outputs only at falling edges. It checks each set at the falling edge that follows the edge that produced it, and it looks for done and a dropped valid at the first falling edge after the last step. It checks the hold and ignored-start cases after several edges with no step, before stepping again.

// File: rtl/fft_agu_pkg.sv
package fft_agu_pkg;
    localparam int AGU_ADDR_W  = 7;  // 128-word data memory
    localparam int AGU_MAX_LOG = 5;  // largest transform: 32 points
    localparam int AGU_SEL_W   = 3;

    typedef enum logic {
        PASS_BFLY    = 1'b0,
        PASS_REORDER = 1'b1
    } pass_e;
endpackage

// File: rtl/fft_agu_ctrl.sv
module fft_agu_ctrl
    import fft_agu_pkg::*;
#(
    parameter int ADDR_W  = AGU_ADDR_W,
    parameter int MAX_LOG = AGU_MAX_LOG,
    parameter int SEL_W   = AGU_SEL_W,
    localparam int IDX_W  = MAX_LOG,
    localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [SEL_W-1:0]  size_sel_i,
    input  logic [ADDR_W-1:0] data_base_i,
    input  logic [ADDR_W-1:0] twid_base_i,
    input  logic              step_i,
    output logic              busy_o,
    output logic              done_o,
    output pass_e             pass_o,
    output logic [LOG_W-1:0]  log2n_o,
    output logic [LOG_W-1:0]  stage_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] dbase_o,
    output logic [ADDR_W-1:0] tbase_o
);
    typedef struct packed {
        logic              busy;
        logic              done;
        pass_e             pass;
        logic [LOG_W-1:0]  log2n;
        logic [LOG_W-1:0]  stage;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] dbase;
        logic [ADDR_W-1:0] tbase;
    } seq_t;

    seq_t r_d, r_q;
    logic [LOG_W-1:0] sel_log;
    logic [IDX_W-1:0] last_idx;
    logic [LOG_W-1:0] last_stage;

    always_comb begin
        if (int'(size_sel_i) < MAX_LOG - 1) sel_log = LOG_W'(int'(size_sel_i) + 2);
        else                                sel_log = LOG_W'(2);

        if (r_q.pass == PASS_REORDER) begin
            last_idx   = IDX_W'((1 << r_q.log2n) - 1);
            last_stage = '0;
        end else begin
            last_idx   = IDX_W'((1 << (r_q.log2n - 1)) - 1);
            last_stage = r_q.log2n - LOG_W'(1);
        end

        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.busy) begin
            if (start_i) begin
                r_d.busy  = 1'b1;
                r_d.pass  = pass_e'(mode_i);
                r_d.log2n = sel_log;
                r_d.stage = '0;
                r_d.idx   = '0;
                r_d.dbase = data_base_i;
                r_d.tbase = twid_base_i;
            end
        end else if (step_i) begin
            if (r_q.idx == last_idx) begin
                r_d.idx = '0;
                if (r_q.stage == last_stage) begin
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.stage = r_q.stage + LOG_W'(1);
                end
            end else begin
                r_d.idx = r_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.log2n <= LOG_W'(2);
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o  = r_q.busy;
    assign done_o  = r_q.done;
    assign pass_o  = r_q.pass;
    assign log2n_o = r_q.log2n;
    assign stage_o = r_q.stage;
    assign idx_o   = r_q.idx;
    assign dbase_o = r_q.dbase;
    assign tbase_o = r_q.tbase;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.done |=> !r_q.done) else $error("done longer than one cycle"); // R9
    AST_DONE_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.done |-> !r_q.busy && $past(r_q.busy && step_i)) else $error("done without final step"); // R9
    AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.busy && !step_i) |=> r_q.busy && $stable(r_q.idx) && $stable(r_q.stage)) else $error("advanced without step"); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.busy && start_i) |=> $stable(r_q.dbase) && $stable(r_q.tbase) && $stable(r_q.log2n)) else $error("restart while busy"); // R10
    AST_STAGE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.busy |-> r_q.stage < r_q.log2n) else $error("stage out of range"); // R4
endmodule

// File: rtl/fft_agu_addr.sv
module fft_agu_addr
    import fft_agu_pkg::*;
#(
    parameter int ADDR_W  = AGU_ADDR_W,
    parameter int MAX_LOG = AGU_MAX_LOG,
    localparam int IDX_W  = MAX_LOG,
    localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
    input  pass_e             pass_i,
    input  logic [LOG_W-1:0]  log2n_i,
    input  logic [LOG_W-1:0]  stage_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] dbase_i,
    input  logic [ADDR_W-1:0] tbase_i,
    output logic [ADDR_W-1:0] addr_a_o,
    output logic [ADDR_W-1:0] addr_b_o,
    output logic [ADDR_W-1:0] twid_o
);
    logic [ADDR_W-1:0] idx_w, span, low, grp, offs, a_tmp;
    logic [LOG_W-1:0]  tw_shift;
    logic [IDX_W-1:0]  rev;

    always_comb begin
        rev = '0;
        for (int b = 0; b < MAX_LOG; b++) begin
            if (b < int'(log2n_i)) rev[b] = idx_i[int'(log2n_i) - 1 - b];
        end

        idx_w    = ADDR_W'(idx_i);
        span     = ADDR_W'(1) << stage_i;
        low      = idx_w & (span - ADDR_W'(1));
        grp      = idx_w >> stage_i;
        offs     = (grp << (stage_i + LOG_W'(1))) | low;
        tw_shift = log2n_i - LOG_W'(1) - stage_i;
        a_tmp    = dbase_i + offs;

        if (pass_i == PASS_REORDER) begin
            addr_a_o = dbase_i + idx_w;
            addr_b_o = dbase_i + ADDR_W'(rev);
            twid_o   = tbase_i;
        end else begin
            addr_a_o = a_tmp;
            addr_b_o = a_tmp + span;
            twid_o   = tbase_i + (low << tw_shift);
        end
    end
endmodule

// File: rtl/fft_agu.sv
module fft_agu
    import fft_agu_pkg::*;
#(
    parameter int ADDR_W  = AGU_ADDR_W,
    parameter int MAX_LOG = AGU_MAX_LOG,
    parameter int SEL_W   = AGU_SEL_W,
    localparam int IDX_W  = MAX_LOG,
    localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [SEL_W-1:0]  size_sel_i,
    input  logic [ADDR_W-1:0] data_base_i,
    input  logic [ADDR_W-1:0] twid_base_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_a_o,
    output logic [ADDR_W-1:0] addr_b_o,
    output logic [ADDR_W-1:0] twid_addr_o,
    output logic              valid_o,
    output logic [LOG_W-1:0]  stage_o,
    output logic [IDX_W-1:0]  bfly_o,
    output logic              done_o
);
    pass_e             pass;
    logic [LOG_W-1:0]  log2n;
    logic [ADDR_W-1:0] dbase, tbase;

    fft_agu_ctrl #(.ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG), .SEL_W(SEL_W)) u_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
        .size_sel_i(size_sel_i), .data_base_i(data_base_i), .twid_base_i(twid_base_i),
        .step_i(step_i), .busy_o(valid_o), .done_o(done_o), .pass_o(pass),
        .log2n_o(log2n), .stage_o(stage_o), .idx_o(bfly_o),
        .dbase_o(dbase), .tbase_o(tbase)
    );

    fft_agu_addr #(.ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG)) u_addr (
        .pass_i(pass), .log2n_i(log2n), .stage_i(stage_o), .idx_i(bfly_o),
        .dbase_i(dbase), .tbase_i(tbase),
        .addr_a_o(addr_a_o), .addr_b_o(addr_b_o), .twid_o(twid_addr_o)
    );

    AST_PAIR_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && pass == PASS_BFLY) |-> (addr_b_o - addr_a_o) == (ADDR_W'(1) << stage_o)) else $error("pair span wrong"); // R5
    AST_HOLD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !step_i) |=> $stable(addr_a_o) && $stable(addr_b_o) && $stable(twid_addr_o)) else $error("addresses moved"); // R8
endmodule

// File: tb/fft_agu_tb.sv
`timescale 1ns/1ps
module fft_agu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, mode = 1'b0, step = 1'b0;
    logic [2:0] size_sel = '0;
    logic [6:0] dbase = '0, tbase = '0;
    logic [6:0] a, b, tw;
    logic       valid, done;
    logic [2:0] stage;
    logic [4:0] bfly;
    int nvec = 0, nfail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fft_agu u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
        .size_sel_i(size_sel), .data_base_i(dbase), .twid_base_i(tbase),
        .step_i(step), .addr_a_o(a), .addr_b_o(b), .twid_addr_o(tw),
        .valid_o(valid), .stage_o(stage), .bfly_o(bfly), .done_o(done)
    );

    // stimulus table: size code, mode, data base, twiddle base, expected set count
    localparam int NCFG = 9;
    localparam int SEL [NCFG] = '{0, 1, 2, 3, 2, 3, 5, 3, 1};
    localparam int MD  [NCFG] = '{0, 0, 0, 0, 1, 1, 0, 0, 1};
    localparam int DB  [NCFG] = '{0, 16, 32, 0, 8, 64, 100, 120, 5};
    localparam int TB  [NCFG] = '{64, 64, 96, 96, 0, 0, 10, 120, 77};
    localparam int CNT [NCFG] = '{4, 12, 32, 80, 16, 32, 4, 80, 8};

    task automatic chk(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int brev(int v, int lg);
        int r = 0;
        for (int i = 0; i < lg; i++) if ((v >> i) & 1) r |= 1 << (lg - 1 - i);
        return r;
    endfunction

    task automatic expect_set(int ea, int eb, int et, int es, int ek);
        chk("R2 valid", int'(valid), 1);
        chk("R5 addr_a", int'(a), ea & 127);
        chk("R5 addr_b", int'(b), eb & 127);
        chk("R6 twiddle", int'(tw), et & 127);
        chk("R4 stage", int'(stage), es);
        chk("R4 bfly", int'(bfly), ek);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic run_cfg(int sel, int md, int db, int tb, int cnt, string tag);
        int lg, nn, n;
        lg = (sel < 4) ? sel + 2 : 2;  // R3
        nn = 1 << lg;
        n  = 0;
        @(negedge clk);
        start = 1'b1; size_sel = sel[2:0]; mode = md[0]; dbase = db[6:0]; tbase = tb[6:0];
        @(negedge clk);
        start = 1'b0;
        if (md == 0) begin
            for (int s = 0; s < lg; s++) begin
                int sp = 1 << s;
                for (int g = 0; g < nn / (2 * sp); g++)
                    for (int j = 0; j < sp; j++) begin
                        expect_set(db + 2*g*sp + j, db + 2*g*sp + j + sp,
                                   tb + j * (nn >> (s + 1)), s, g*sp + j);
                        n++;
                    end
            end
        end else begin
            for (int j = 0; j < nn; j++) begin  // R7
                expect_set(db + j, db + brev(j, lg), tb, 0, j);
                n++;
            end
        end
        chk("R9 done pulse", int'(done), 1);
        chk("R9 valid low at done", int'(valid), 0);
        chk(tag, n, cnt);
        @(negedge clk);
        chk("R9 done one cycle", int'(done), 0);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nvec++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid after reset", int'(valid), 0);
        chk("R1 done after reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 still idle", int'(valid), 0);

        for (int i = 0; i < NCFG; i++)
            run_cfg(SEL[i], MD[i], DB[i], TB[i], CNT[i],
                    (i == 6) ? "R3 size code 5 as 4 points" :
                    (i == 7) ? "R11 wrapped run count" : "R4 set count");

        // R8: no step, outputs hold; R10: restart while busy ignored
        @(negedge clk);
        start = 1'b1; size_sel = 3'd1; mode = 1'b0; dbase = 7'd40; tbase = 7'd0;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 hold valid", int'(valid), 1);
        chk("R8 hold addr_a", int'(a), 40);
        chk("R8 hold addr_b", int'(b), 41);
        chk("R8 hold bfly", int'(bfly), 0);
        start = 1'b1; size_sel = 3'd3; mode = 1'b1; dbase = 7'd90; tbase = 7'd9;
        @(negedge clk);
        start = 1'b0;
        chk("R10 base kept a", int'(a), 40);
        chk("R10 twiddle base kept", int'(tw), 0);
        begin
            int n = 0;
            while (valid && n < 100) begin
                step = 1'b1; @(negedge clk); step = 1'b0; n++;
            end
            chk("R10 size kept (12 sets)", n, 12);
            chk("R9 done after restart test", int'(done), 1);
        end
        @(negedge clk);
        chk("R8 step while idle no effect", int'(valid), 0);
        report();
    end
endmodule